// File: doc/BRIEF.md
# Color and Mask Block-Write Unit

This unit sits in the write path of a 32-bit graphics memory and turns each write command into column strobes, per-bit write enables and write data. It holds one persistent write-mask register and two color registers. All three are loaded by special register-load commands that take their value from the data pins, with the target picked by address bits. The unit also remembers, for each bank, whether the open row was opened by a masked activate. Only such rows apply the write-mask register.

A normal write targets one column inside an eight-column group. A block write fills any subset of the eight columns of a group in a single cycle with a color value. The subset is chosen by the low eight data pins, and the color comes from one of the two registers. Per-byte data masks always apply. Every write command appears on the outputs one clock after it is sampled. Storage, refresh and checks on command legality belong to the surrounding controller.

Top module: `cbw_write_unit`

## Requirements
- R1: After synchronous reset the outputs are all zero, the write-mask register is all ones, both color registers are zero and every bank's masked-row flag is clear.
- R2: Commands are encoded on `cmd` as 0 idle, 1 activate, 2 masked activate, 3 precharge, 4 write, 5 block write, 6 register load (7 acts as idle). The outputs are registered and show the result one cycle after the command is sampled. In a cycle following a non-write command, `wr_valid`, `col_strobe` and `bit_we` are zero.
- R3: A register load whose address equals exactly bit 5 set (0x020) copies `dq` into the write-mask register.
- R4: In two-color mode (`two_color`=1), a register load with address bit 6 set, and no other bit set except bit 7, copies `dq` into color register 0 when bit 7 is 0 and into color register 1 when bit 7 is 1.
- R5: In one-color mode, a color load is accepted only with the address exactly 0x040, and it always targets color register 0. An address of 0x0C0 is rejected.
- R6: A register load that matches neither R3 nor R4/R5 changes no register. It raises `load_reject` for exactly the one cycle after the command.
- R7: Masked activate sets the masked-row flag of the addressed bank. Activate or precharge clears it. Other banks are unaffected.
- R8: Writes to a bank whose flag is set are gated bitwise by the write-mask register. Writes to a bank whose flag is clear ignore that register.
- R9: `dqm[i]`=1 forces `bit_we[8i+7:8i]` to zero on every write and block write, whatever the row state.
- R10: A write drives `wr_data`=`dq`, `col_group`=address bits 7:3, and `col_strobe` one-hot at the position given by address bits 2:0.
- R11: A block write is a single output cycle. It drives `col_group`=address bits 7:3 and `col_strobe`=`dq[7:0]`, where a zero bit suppresses that column. With `dq[7:0]`=0, `wr_valid` is 1 and no column is strobed.
- R12: A block write's `wr_data` is color register 1 when two-color mode is on and address bit 0 is 1. Otherwise it is color register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code (see R2) |
| bank | input | 1 | Bank selected by the command |
| addr | input | 10 | Address pins |
| dq | input | 32 | Data pins: write data, register-load value, or block-write column enables |
| dqm | input | 4 | Per-byte data mask, 1 blocks the byte |
| two_color | input | 1 | 1 selects two-color mode |
| wr_valid | output | 1 | A write or block write is being issued |
| wr_bank | output | 1 | Bank of the issued write |
| col_group | output | 5 | Eight-column group index |
| col_strobe | output | 8 | Per-column write strobe within the group |
| bit_we | output | 32 | Per-bit write enable shared by strobed columns |
| wr_data | output | 32 | Data written to strobed columns |
| load_reject | output | 1 | One-cycle flag for an ignored register load |

## Verification
On every cycle, the checker confirms several relations. A write yields exactly one strobe, and idle cycles give quiet outputs. A masked byte never reaches `bit_we`. An unmasked write to a plain row enables all bits. A masked activate leaves the flag of its bank set. Malformed loads raise the reject flag without moving the mask register, and a one-color block write carries color register 0. Only the bench scenarios can show that a loaded value later comes back through a masked write or block write. They also show the two-color selection by address bit 0, flag clearing by precharge, and the isolation between banks.

// File: rtl/cbw_pkg.sv
package cbw_pkg;

    parameter int DQ_W           = 32;
    parameter int BYTE_W         = 8;
    parameter int BYTE_CNT       = DQ_W / BYTE_W;
    parameter int ADDR_W         = 10;
    parameter int BANK_CNT       = 2;
    parameter int BANK_W         = (BANK_CNT > 1) ? $clog2(BANK_CNT) : 1;
    parameter int GROUP_COLS     = 8;
    parameter int COL_SEL_W      = $clog2(GROUP_COLS);
    parameter int GROUP_HI       = 7;
    parameter int GROUP_W        = GROUP_HI - COL_SEL_W + 1;
    parameter int COLOR_CNT      = 2;
    parameter int MASK_LOAD_BIT  = 5;
    parameter int COLOR_LOAD_BIT = 6;
    parameter int COLOR_IDX_BIT  = 7;
    parameter int BW_COLOR_BIT   = 0;

    typedef enum logic [2:0] {
        CMD_IDLE = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_ACTM = 3'd2,
        CMD_PRE  = 3'd3,
        CMD_WR   = 3'd4,
        CMD_BW   = 3'd5,
        CMD_LOAD = 3'd6,
        CMD_RSVD = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        LD_NONE  = 2'd0,
        LD_MASK  = 2'd1,
        LD_COLOR = 2'd2,
        LD_BAD   = 2'd3
    } ld_kind_e;

    typedef struct packed {
        logic                  valid;
        logic [BANK_W-1:0]     bank;
        logic [GROUP_W-1:0]    group;
        logic [GROUP_COLS-1:0] strobe;
        logic [DQ_W-1:0]       bit_en;
        logic [DQ_W-1:0]       data;
    } wr_beat_t;

    // Expand active-high byte blocks into active-high bit enables.
    function automatic logic [DQ_W-1:0] byte_enables(input logic [BYTE_CNT-1:0] blocked);
        logic [DQ_W-1:0] r;
        for (int b = 0; b < BYTE_CNT; b++) begin
            r[b*BYTE_W +: BYTE_W] = {BYTE_W{~blocked[b]}};
        end
        return r;
    endfunction

    function automatic logic [GROUP_COLS-1:0] col_onehot(input logic [COL_SEL_W-1:0] sel);
        logic [GROUP_COLS-1:0] r;
        r = '0;
        r[sel] = 1'b1;
        return r;
    endfunction

    // Decode the target of a register-load command.
    function automatic ld_kind_e classify_load(input logic [ADDR_W-1:0] a,
                                               input logic two_mode);
        logic [ADDR_W-1:0] mask_pat;
        logic [ADDR_W-1:0] allowed;
        mask_pat = ADDR_W'(1) << MASK_LOAD_BIT;
        allowed  = ADDR_W'(1) << COLOR_LOAD_BIT;
        if (two_mode) begin
            allowed = allowed | (ADDR_W'(1) << COLOR_IDX_BIT);
        end
        if (a == mask_pat) begin
            return LD_MASK;
        end else if (a[COLOR_LOAD_BIT] && ((a & ~allowed) == '0)) begin
            return LD_COLOR;
        end
        return LD_BAD;
    endfunction

endpackage

// File: rtl/cbw_special_regs.sv
module cbw_special_regs
    import cbw_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            load_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DQ_W-1:0]                 dq,
    input  logic                            two_color,
    output logic [DQ_W-1:0]                 mask_q,
    output logic [COLOR_CNT-1:0][DQ_W-1:0]  color_q,
    output logic                            reject_q
);

    ld_kind_e kind;
    logic     color_idx;

    assign kind      = load_en ? classify_load(addr, two_color) : LD_NONE;
    assign color_idx = two_color ? addr[COLOR_IDX_BIT] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '1;
            reject_q <= 1'b0;
        end else begin
            if (kind == LD_MASK) begin
                mask_q <= dq;
            end
            reject_q <= (kind == LD_BAD);
        end
    end

    for (genvar g = 0; g < COLOR_CNT; g++) begin : g_color
        always_ff @(posedge clk) begin
            if (rst) begin
                color_q[g] <= '0;
            end else if (kind == LD_COLOR && color_idx == 1'(g)) begin
                color_q[g] <= dq;
            end
        end
    end

endmodule

// File: rtl/cbw_row_flags.sv
module cbw_row_flags
    import cbw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  cmd_e                cmd,
    input  logic [BANK_W-1:0]   bank,
    output logic [BANK_CNT-1:0] row_masked
);

    for (genvar b = 0; b < BANK_CNT; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                row_masked[b] <= 1'b0;
            end else if (bank == BANK_W'(b)) begin
                case (cmd)
                    CMD_ACTM:         row_masked[b] <= 1'b1;
                    CMD_ACT, CMD_PRE: row_masked[b] <= 1'b0;
                    default:          row_masked[b] <= row_masked[b];
                endcase
            end
        end
    end

endmodule

// File: rtl/cbw_enable_build.sv
module cbw_enable_build
    import cbw_pkg::*;
(
    input  cmd_e                            cmd,
    input  logic [BANK_W-1:0]               bank,
    input  logic [GROUP_HI:0]               addr_lo,
    input  logic [DQ_W-1:0]                 dq,
    input  logic [BYTE_CNT-1:0]             dqm,
    input  logic                            two_color,
    input  logic [BANK_CNT-1:0]             row_masked,
    input  logic [DQ_W-1:0]                 mask_q,
    input  logic [COLOR_CNT-1:0][DQ_W-1:0]  color_q,
    output wr_beat_t                        beat
);

    logic [DQ_W-1:0] gate;
    logic            color_sel;

    assign gate      = byte_enables(dqm) & (row_masked[bank] ? mask_q : '1);
    assign color_sel = two_color & addr_lo[BW_COLOR_BIT];

    always_comb begin
        beat = '0;
        case (cmd)
            CMD_WR: begin
                beat.valid  = 1'b1;
                beat.bank   = bank;
                beat.group  = addr_lo[GROUP_HI:COL_SEL_W];
                beat.strobe = col_onehot(addr_lo[COL_SEL_W-1:0]);
                beat.bit_en = gate;
                beat.data   = dq;
            end
            CMD_BW: begin
                beat.valid  = 1'b1;
                beat.bank   = bank;
                beat.group  = addr_lo[GROUP_HI:COL_SEL_W];
                beat.strobe = dq[GROUP_COLS-1:0];
                beat.bit_en = gate;
                beat.data   = color_q[color_sel];
            end
            default: beat = '0;
        endcase
    end

endmodule

// File: rtl/cbw_write_unit.sv
module cbw_write_unit
    import cbw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2:0]            cmd,
    input  logic [BANK_W-1:0]     bank,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DQ_W-1:0]       dq,
    input  logic [BYTE_CNT-1:0]   dqm,
    input  logic                  two_color,
    output logic                  wr_valid,
    output logic [BANK_W-1:0]     wr_bank,
    output logic [GROUP_W-1:0]    col_group,
    output logic [GROUP_COLS-1:0] col_strobe,
    output logic [DQ_W-1:0]       bit_we,
    output logic [DQ_W-1:0]       wr_data,
    output logic                  load_reject
);

    cmd_e                           cmd_c;
    logic [DQ_W-1:0]                mask_q;
    logic [COLOR_CNT-1:0][DQ_W-1:0] color_q;
    logic [BANK_CNT-1:0]            row_masked;
    wr_beat_t                       beat_d;
    wr_beat_t                       beat_q;

    assign cmd_c = cmd_e'(cmd);

    cbw_special_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .load_en   (cmd_c == CMD_LOAD),
        .addr      (addr),
        .dq        (dq),
        .two_color (two_color),
        .mask_q    (mask_q),
        .color_q   (color_q),
        .reject_q  (load_reject)
    );

    cbw_row_flags u_rows (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd_c),
        .bank       (bank),
        .row_masked (row_masked)
    );

    cbw_enable_build u_build (
        .cmd        (cmd_c),
        .bank       (bank),
        .addr_lo    (addr[GROUP_HI:0]),
        .dq         (dq),
        .dqm        (dqm),
        .two_color  (two_color),
        .row_masked (row_masked),
        .mask_q     (mask_q),
        .color_q    (color_q),
        .beat       (beat_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    assign wr_valid   = beat_q.valid;
    assign wr_bank    = beat_q.bank;
    assign col_group  = beat_q.group;
    assign col_strobe = beat_q.strobe;
    assign bit_we     = beat_q.bit_en;
    assign wr_data    = beat_q.data;

endmodule

// File: rtl/cbw_write_unit_chk.sv
module cbw_write_unit_chk
    import cbw_pkg::*;
(
    input logic                           clk,
    input logic                           rst,
    input logic [2:0]                     cmd,
    input logic [BANK_W-1:0]              bank,
    input logic [ADDR_W-1:0]              addr,
    input logic [BYTE_CNT-1:0]            dqm,
    input logic                           two_color,
    input logic                           wr_valid,
    input logic [GROUP_COLS-1:0]          col_strobe,
    input logic [DQ_W-1:0]                bit_we,
    input logic [DQ_W-1:0]                wr_data,
    input logic                           load_reject,
    input logic [DQ_W-1:0]                mask_q,
    input logic [COLOR_CNT-1:0][DQ_W-1:0] color_q,
    input logic [BANK_CNT-1:0]            row_masked
);

    logic is_write;
    logic bad_bits;
    assign is_write = (cmd == CMD_WR) || (cmd == CMD_BW);
    // Any address bit outside the three load-select positions is illegal.
    assign bad_bits = (addr & ~((ADDR_W'(1) << MASK_LOAD_BIT) |
                                (ADDR_W'(1) << COLOR_LOAD_BIT) |
                                (ADDR_W'(1) << COLOR_IDX_BIT))) != '0;

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !is_write |=> (!wr_valid && col_strobe == '0 && bit_we == '0));

    a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_WR) |=> (wr_valid && $countones(col_strobe) == 1));

    a_r9_byte0_blocked: assert property (@(posedge clk) disable iff (rst)
        (is_write && dqm[0]) |=> (bit_we[BYTE_W-1:0] == '0));

    a_r8_plain_row_open: assert property (@(posedge clk) disable iff (rst)
        (is_write && !row_masked[bank] && dqm == '0) |=> (bit_we == '1));

    a_r7_actm_sets: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ACTM) |=> row_masked[$past(bank)]);

    a_r6_bad_load_flag: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD && bad_bits) |=> load_reject);

    a_r6_reject_keeps_mask: assert property (@(posedge clk) disable iff (rst)
        load_reject |-> $stable(mask_q));

    a_r12_one_color_data: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_BW && !two_color) |=> (wr_data == $past(color_q[0])));

endmodule

bind cbw_write_unit cbw_write_unit_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .cmd         (cmd),
    .bank        (bank),
    .addr        (addr),
    .dqm         (dqm),
    .two_color   (two_color),
    .wr_valid    (wr_valid),
    .col_strobe  (col_strobe),
    .bit_we      (bit_we),
    .wr_data     (wr_data),
    .load_reject (load_reject),
    .mask_q      (mask_q),
    .color_q     (color_q),
    .row_masked  (row_masked)
);

// File: tb/cbw_write_unit_tb_top.sv
module cbw_write_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] C_IDLE = 3'd0, C_ACT = 3'd1, C_ACTM = 3'd2, C_PRE = 3'd3,
                           C_WR = 3'd4, C_BW = 3'd5, C_LOAD = 3'd6;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  cmd;
    logic [0:0]  bank;
    logic [9:0]  addr;
    logic [31:0] dq;
    logic [3:0]  dqm;
    logic        two_color;
    logic        wr_valid;
    logic [0:0]  wr_bank;
    logic [4:0]  col_group;
    logic [7:0]  col_strobe;
    logic [31:0] bit_we;
    logic [31:0] wr_data;
    logic        load_reject;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cbw_write_unit dut_i (
        .clk(clk), .rst(rst), .cmd(cmd), .bank(bank), .addr(addr), .dq(dq),
        .dqm(dqm), .two_color(two_color), .wr_valid(wr_valid), .wr_bank(wr_bank),
        .col_group(col_group), .col_strobe(col_strobe), .bit_we(bit_we),
        .wr_data(wr_data), .load_reject(load_reject)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one command, let it pass one edge, leave outputs ready to sample.
    task automatic issue(input logic [2:0] c, input logic [0:0] b, input logic [9:0] a,
                         input logic [31:0] d, input logic [3:0] m);
        @(negedge clk);
        cmd = c; bank = b; addr = a; dq = d; dqm = m;
        @(posedge clk);
        #1;
        cmd = C_IDLE; addr = '0; dq = '0; dqm = '0;
    endtask

    task automatic t_reset();
        chk("R1 valid", {31'd0, wr_valid}, 32'd0);
        chk("R1 we", bit_we, 32'd0);
        chk("R1 reject", {31'd0, load_reject}, 32'd0);
        two_color = 1'b0;
        issue(C_BW, 1'b0, 10'h000, 32'h0000_00FF, 4'h0);
        chk("R1 color0 zero", wr_data, 32'h0);
        chk("R1 plain row all bits", bit_we, 32'hFFFF_FFFF);
    endtask

    task automatic t_write();
        issue(C_WR, 1'b1, 10'h0F5, 32'hDEAD_BEEF, 4'h0);
        chk("R10 valid", {31'd0, wr_valid}, 32'd1);
        chk("R10 bank", {31'd0, wr_bank}, 32'd1);
        chk("R10 group", {27'd0, col_group}, 32'h1E);
        chk("R10 strobe", {24'd0, col_strobe}, 32'h20);
        chk("R10 data", wr_data, 32'hDEAD_BEEF);
        issue(C_IDLE, 1'b0, 10'h000, 32'h0, 4'h0);
        chk("R2 idle valid", {31'd0, wr_valid}, 32'd0);
        chk("R2 idle strobe", {24'd0, col_strobe}, 32'd0);
        issue(C_ACT, 1'b0, 10'h3FF, 32'hFFFF_FFFF, 4'h0);
        chk("R2 act quiet", bit_we, 32'd0);
    endtask

    task automatic t_block_cols();
        issue(C_BW, 1'b0, 10'h0A8, 32'hFFFF_FF3C, 4'h0);
        chk("R11 strobe", {24'd0, col_strobe}, 32'h3C);
        chk("R11 group", {27'd0, col_group}, 32'h15);
        issue(C_BW, 1'b0, 10'h0A8, 32'hFFFF_FF00, 4'h0);
        chk("R11 zero pattern valid", {31'd0, wr_valid}, 32'd1);
        chk("R11 zero pattern strobe", {24'd0, col_strobe}, 32'd0);
        issue(C_IDLE, 1'b0, 10'h000, 32'h0, 4'h0);
        chk("R11 single cycle", {31'd0, wr_valid}, 32'd0);
    endtask

    task automatic t_mask();
        issue(C_LOAD, 1'b0, 10'h020, 32'h0000_FFFF, 4'h0);
        chk("R3 accepted", {31'd0, load_reject}, 32'd0);
        issue(C_ACTM, 1'b0, 10'h000, 32'h0, 4'h0);
        issue(C_WR, 1'b0, 10'h001, 32'h1234_5678, 4'h0);
        chk("R3 R8 masked row", bit_we, 32'h0000_FFFF);
        issue(C_ACT, 1'b1, 10'h000, 32'h0, 4'h0);
        issue(C_WR, 1'b1, 10'h001, 32'h1234_5678, 4'h0);
        chk("R8 plain row", bit_we, 32'hFFFF_FFFF);
        issue(C_WR, 1'b0, 10'h002, 32'h0, 4'h0);
        chk("R7 other bank kept", bit_we, 32'h0000_FFFF);
    endtask

    task automatic t_dqm();
        issue(C_WR, 1'b0, 10'h000, 32'h0, 4'b0001);
        chk("R9 masked row byte0", bit_we, 32'h0000_FF00);
        issue(C_WR, 1'b1, 10'h000, 32'h0, 4'b1010);
        chk("R9 plain row", bit_we, 32'h00FF_00FF);
        issue(C_BW, 1'b1, 10'h000, 32'h0000_00FF, 4'b1111);
        chk("R9 block write all blocked", bit_we, 32'h0);
    endtask

    task automatic t_rows();
        issue(C_ACTM, 1'b1, 10'h000, 32'h0, 4'h0);
        issue(C_WR, 1'b1, 10'h000, 32'h0, 4'h0);
        chk("R7 actm bank1", bit_we, 32'h0000_FFFF);
        issue(C_PRE, 1'b1, 10'h000, 32'h0, 4'h0);
        issue(C_WR, 1'b1, 10'h000, 32'h0, 4'h0);
        chk("R7 pre clears", bit_we, 32'hFFFF_FFFF);
        issue(C_ACT, 1'b0, 10'h000, 32'h0, 4'h0);
        issue(C_WR, 1'b0, 10'h000, 32'h0, 4'h0);
        chk("R7 act clears", bit_we, 32'hFFFF_FFFF);
    endtask

    task automatic t_reject();
        issue(C_ACTM, 1'b0, 10'h000, 32'h0, 4'h0);
        issue(C_LOAD, 1'b0, 10'h021, 32'hFFFF_0000, 4'h0);
        chk("R6 stray bit0", {31'd0, load_reject}, 32'd1);
        issue(C_IDLE, 1'b0, 10'h000, 32'h0, 4'h0);
        chk("R6 one cycle", {31'd0, load_reject}, 32'd0);
        issue(C_LOAD, 1'b0, 10'h060, 32'hFFFF_0000, 4'h0);
        chk("R6 mask and color", {31'd0, load_reject}, 32'd1);
        issue(C_LOAD, 1'b0, 10'h220, 32'hFFFF_0000, 4'h0);
        chk("R6 stray bit9", {31'd0, load_reject}, 32'd1);
        issue(C_WR, 1'b0, 10'h000, 32'h0, 4'h0);
        chk("R6 mask unchanged", bit_we, 32'h0000_FFFF);
    endtask

    task automatic t_two_color();
        two_color = 1'b1;
        issue(C_LOAD, 1'b0, 10'h040, 32'hA5A5_A5A5, 4'h0);
        issue(C_LOAD, 1'b0, 10'h0C0, 32'h5A5A_5A5A, 4'h0);
        chk("R4 idx load accepted", {31'd0, load_reject}, 32'd0);
        issue(C_BW, 1'b1, 10'h0A9, 32'h0000_0001, 4'h0);
        chk("R12 R4 color1", wr_data, 32'h5A5A_5A5A);
        issue(C_BW, 1'b1, 10'h0A8, 32'h0000_0001, 4'h0);
        chk("R12 R4 color0", wr_data, 32'hA5A5_A5A5);
    endtask

    task automatic t_one_color();
        two_color = 1'b0;
        issue(C_LOAD, 1'b0, 10'h0C0, 32'hFFFF_FFFF, 4'h0);
        chk("R5 bit7 rejected", {31'd0, load_reject}, 32'd1);
        issue(C_BW, 1'b1, 10'h001, 32'h0000_0001, 4'h0);
        chk("R5 R12 addr0 ignored", wr_data, 32'hA5A5_A5A5);
        issue(C_LOAD, 1'b0, 10'h040, 32'h1122_3344, 4'h0);
        issue(C_BW, 1'b1, 10'h001, 32'h0000_0001, 4'h0);
        chk("R5 load to color0", wr_data, 32'h1122_3344);
        two_color = 1'b1;
        issue(C_BW, 1'b1, 10'h001, 32'h0000_0001, 4'h0);
        chk("R5 color1 untouched", wr_data, 32'h5A5A_5A5A);
    endtask

    initial begin
        rst = 1'b1; cmd = C_IDLE; bank = '0; addr = '0; dq = '0; dqm = '0; two_color = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        t_reset_entry();
    end

    task automatic t_reset_entry();
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write();
        t_block_cols();
        t_mask();
        t_dqm();
        t_rows();
        t_reject();
        t_two_color();
        t_one_color();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule